// File: doc/BRIEF.md
# Configurable Rearrangeable Switch Fabric

A parameterised N×N rearrangeable switching network (N a power of two, 8 by default) that carries W-bit data words from N input ports to N output ports. It is built from 2·log2(N)−1 columns of 2×2 switching elements, each column holding N/2 elements. The element in row j of a column serves ports 2j and 2j+1. The wiring between columns is fixed. In the first log2(N)−1 gaps the low bits of the port address are rotated right by one, and the span of the rotation shrinks as the column index grows. The remaining gaps undo those rotations in mirror order, rotating the same spans left by one. With every element set straight the fabric therefore reduces to the identity.

Each element holds one of three states: unconfigured, straight or cross. A path-setup controller, which sits outside this block, writes the states one element at a time. It can also wipe the whole store with a single strobe, and it reads states back through a combinational read port. The block computes no routes. Data flows combinationally from the inputs to the outputs under the stored configuration. Any output whose path crosses an unconfigured element carries zero data and a low valid flag.

Top module: `benes_fabric`

## Requirements
- R1: After reset every element is unconfigured: all bits of `out_valid` and `out_data` are 0, and the read port returns 2'b00 for every element.
- R2: The state encoding is 2'b00 unconfigured, 2'b10 straight and 2'b11 cross. A write with `wr_en` high stores `wr_state` at element (`wr_stage`, `wr_row`) on the next rising clock edge, and the read port then returns the stored value.
- R3: With every element straight, output port i carries input word i and every valid bit is 1.
- R4: In a straight element a word stays on its port. In a crossed element it moves to the partner port (i+1 for even i, i−1 for odd i). For N=8, crossing every element of stage k, with all other elements straight, makes output i carry input i XOR F, where F is 1, 2, 4, 2 and 1 for stages 0 to 4. Crossing several whole stages XORs their F values together.
- R5: An output whose path passes an unconfigured element has valid 0 and data 0, and the other outputs are unaffected. For N=8 with all other elements straight: element row 0 of stage 2 blocks outputs 0 and 4, and element row 1 of stage 0 blocks outputs 2 and 3.
- R6: A `clr_all` strobe returns every element to unconfigured on the next edge and takes priority over a write in the same cycle.
- R7: A write whose `wr_stage` is not below 2·log2(N)−1 changes nothing, and the read port returns 2'b00 for such a stage.
- R8: For a fixed configuration, `out_data` follows `in_data` with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the state store |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_all | input | 1 | Sets every element to unconfigured |
| wr_en | input | 1 | Element state write strobe |
| wr_stage | input | SW | Stage index of the write |
| wr_row | input | RW | Row index of the write |
| wr_state | input | 2 | State to store |
| rd_stage | input | SW | Stage index of the read |
| rd_row | input | RW | Row index of the read |
| rd_state | output | 2 | Stored state of the addressed element |
| in_data | input | N*W | Input words, word i at bits i*W +: W |
| out_data | output | N*W | Output words, word i at bits i*W +: W |
| out_valid | output | N | Per-output path-configured flag |

## Verification
On every cycle the assertions check these points. A write lands at its addressed element, and a clear or an out-of-range write leaves the expected store. A fully unconfigured store yields silent outputs. A fully configured store yields all outputs valid. An all-straight store behaves as the identity. Only the bench scenarios can show that the inter-stage rotations really form the intended network. It does so through the per-stage XOR signatures of whole-stage crossings, the exact ports blocked by a single unconfigured element, and a lone crossed element swapping just its own pair.

// File: rtl/benes_fabric.sv
module benes_fabric #(
  parameter int N = 8,
  parameter int W = 8,
  // derived, keep at defaults
  parameter int LOGN = $clog2(N),
  parameter int STAGES = 2 * LOGN - 1,
  parameter int HALF = N / 2,
  parameter int SW = (STAGES > 1) ? $clog2(STAGES) : 1,
  parameter int RW = (HALF > 1) ? $clog2(HALF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_all,
  input  logic            wr_en,
  input  logic [SW-1:0]   wr_stage,
  input  logic [RW-1:0]   wr_row,
  input  logic [1:0]      wr_state,
  input  logic [SW-1:0]   rd_stage,
  input  logic [RW-1:0]   rd_row,
  output logic [1:0]      rd_state,
  input  logic [N*W-1:0]  in_data,
  output logic [N*W-1:0]  out_data,
  output logic [N-1:0]    out_valid
);

  localparam logic [STAGES*HALF*2-1:0] ALL_STRAIGHT = {STAGES*HALF{2'b10}};

  // port address after the link that follows stage k
  function automatic int link_map(input int k, input int p);
    int w, lo, hi;
    if (k < LOGN - 1) begin
      w  = LOGN - k;
      lo = p % (1 << w);
      hi = p - lo;
      return hi + ((lo >> 1) | ((lo & 1) << (w - 1)));
    end else begin
      w  = LOGN - (2 * LOGN - 3 - k);
      lo = p % (1 << w);
      hi = p - lo;
      return hi + (((lo << 1) & ((1 << w) - 1)) | (lo >> (w - 1)));
    end
  endfunction

  logic [STAGES-1:0][HALF-1:0][1:0] cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  cfg <= '0;
    else if (clr_all)                            cfg <= '0;
    else if (wr_en && 32'(wr_stage) < STAGES)    cfg[wr_stage][wr_row] <= wr_state;
  end

  assign rd_state = (32'(rd_stage) < STAGES) ? cfg[rd_stage][rd_row] : 2'b00;

  logic [N-1:0][W-1:0] sin  [STAGES];
  logic [N-1:0][W-1:0] sout [STAGES];
  logic [N-1:0]        vin  [STAGES];
  logic [N-1:0]        vout [STAGES];

  assign sin[0] = in_data;
  assign vin[0] = '1;

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    for (genvar j = 0; j < HALF; j++) begin : g_elem
      logic [1:0] st;
      assign st = cfg[k][j];
      assign sout[k][2*j]   = !st[1] ? '0 : (st[0] ? sin[k][2*j+1] : sin[k][2*j]);
      assign sout[k][2*j+1] = !st[1] ? '0 : (st[0] ? sin[k][2*j]   : sin[k][2*j+1]);
      assign vout[k][2*j]   = st[1] & (st[0] ? vin[k][2*j+1] : vin[k][2*j]);
      assign vout[k][2*j+1] = st[1] & (st[0] ? vin[k][2*j]   : vin[k][2*j+1]);
    end
    if (k < STAGES - 1) begin : g_link
      for (genvar p = 0; p < N; p++) begin : g_port
        localparam int D = link_map(k, p);
        assign sin[k+1][D] = sout[k][p];
        assign vin[k+1][D] = vout[k][p];
      end
    end
  end

  assign out_data  = sout[STAGES-1];
  assign out_valid = vout[STAGES-1];

  logic all_cfg;
  always_comb begin
    all_cfg = 1'b1;
    for (int k = 0; k < STAGES; k++)
      for (int j = 0; j < HALF; j++)
        if (!cfg[k][j][1]) all_cfg = 1'b0;
  end

  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all && 32'(wr_stage) < STAGES) |=>
      cfg[$past(wr_stage)][$past(wr_row)] == $past(wr_state));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> cfg == '0);

  p_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr_all && 32'(wr_stage) >= STAGES) |=> $stable(cfg));

  p_silent_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == '0) |-> (out_valid == '0 && out_data == '0));

  p_identity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == ALL_STRAIGHT) |-> (out_data == in_data && out_valid == '1));

  p_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    all_cfg |-> out_valid == '1);

endmodule

// File: tb/tb_benes_fabric.sv
`timescale 1ns/1ps
module tb_benes_fabric;
  localparam int N = 8, W = 8, STAGES = 5;
  localparam logic [1:0] UNC = 2'b00, STR = 2'b10, CRS = 2'b11;

  // whole-stage cross masks, bit k = stage k crossed
  localparam logic [4:0] MASKS [6] = '{5'b00000, 5'b00001, 5'b00100,
                                       5'b00010, 5'b11111, 5'b01010};

  logic clk = 0, rst_n = 0, clr_all = 0, wr_en = 0;
  logic [2:0] wr_stage = 0, rd_stage = 0;
  logic [1:0] wr_row = 0, rd_row = 0, wr_state = 0, rd_state;
  logic [N*W-1:0] in_data = '0, out_data;
  logic [N-1:0] out_valid;
  int runs = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  benes_fabric #(.N(N), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .wr_en(wr_en),
    .wr_stage(wr_stage), .wr_row(wr_row), .wr_state(wr_state),
    .rd_stage(rd_stage), .rd_row(rd_row), .rd_state(rd_state),
    .in_data(in_data), .out_data(out_data), .out_valid(out_valid));

  function automatic int stage_flip(input int k);
    case (k)
      0, 4: return 1;
      1, 3: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [N*W-1:0] xor_perm(input logic [N*W-1:0] d, input int f);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = d[(i ^ f)*W +: W];
    return r;
  endfunction

  function automatic logic [N*W-1:0] pattern(input int s);
    logic [N*W-1:0] r;
    for (int i = 0; i < N; i++) r[i*W +: W] = 8'(s * 37 + i * 17 + 5);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int k, input int r, input logic [1:0] s);
    @(negedge clk);
    wr_en = 1; wr_stage = 3'(k); wr_row = 2'(r); wr_state = s;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_stage(input int k, input logic [1:0] s);
    for (int r = 0; r < N/2; r++) wr(k, r, s);
  endtask

  task automatic set_all(input logic [1:0] s);
    for (int k = 0; k < STAGES; k++) set_stage(k, s);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] exp_d;
    in_data = pattern(1);
    #7 rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 valid", 64'(out_valid), 64'h0);
    check("R1 data", out_data, 64'h0);
    rd_stage = 2; rd_row = 1; #1;
    check("R1 read", 64'(rd_state), 64'(UNC));

    // R2 write then read back
    wr(3, 2, CRS);
    rd_stage = 3; rd_row = 2; #1;
    check("R2 readback cross", 64'(rd_state), 64'(CRS));
    wr(3, 2, STR); #1;
    check("R2 readback straight", 64'(rd_state), 64'(STR));

    // R3 / R4 vector table of whole-stage crossings
    for (int v = 0; v < 6; v++) begin
      int f;
      f = 0;
      for (int k = 0; k < STAGES; k++) begin
        set_stage(k, MASKS[v][k] ? CRS : STR);
        if (MASKS[v][k]) f ^= stage_flip(k);
      end
      in_data = pattern(v + 2); #1;
      check(v == 0 ? "R3 identity" : "R4 stage cross", out_data, xor_perm(in_data, f));
      check(v == 0 ? "R3 valid" : "R4 valid", 64'(out_valid), 64'hFF);
      // R8 new data with no clock edge
      in_data = pattern(v + 40); #1;
      check("R8 combinational", out_data, xor_perm(in_data, f));
    end

    // R4 single element cross
    set_all(STR);
    wr(0, 0, CRS); #1;
    exp_d = in_data;
    exp_d[0 +: W] = in_data[W +: W];
    exp_d[W +: W] = in_data[0 +: W];
    check("R4 single element", out_data, exp_d);

    // R5 unconfigured elements
    set_all(STR);
    wr(2, 0, UNC); #1;
    check("R5 mid valid", 64'(out_valid), 64'hEE);
    exp_d = in_data;
    exp_d[0 +: W] = '0;
    exp_d[4*W +: W] = '0;
    check("R5 mid data", out_data, exp_d);
    wr(0, 1, UNC); #1;
    check("R5 first-stage valid", 64'(out_valid), 64'hE2);

    // R7 out-of-range stage write ignored
    set_all(STR);
    wr(5, 0, UNC); #1;
    check("R7 outputs", out_data, in_data);
    check("R7 valid", 64'(out_valid), 64'hFF);
    rd_stage = 5; rd_row = 0; #1;
    check("R7 read", 64'(rd_state), 64'(UNC));

    // R6 clear wins over write
    @(negedge clk);
    clr_all = 1; wr_en = 1; wr_stage = 1; wr_row = 3; wr_state = CRS;
    @(negedge clk);
    clr_all = 0; wr_en = 0;
    rd_stage = 1; rd_row = 3; #1;
    check("R6 valid", 64'(out_valid), 64'h0);
    check("R6 data", out_data, 64'h0);
    check("R6 read", 64'(rd_state), 64'(UNC));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule